// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block gathers a large set of peripheral interrupt sources and funnels them onto a small number of CPU interrupt lines. Sources are organised in groups; every source owns a pending flag and an enable bit, and every group owns one CPU line, one CPU-level flag, one CPU-level enable and one acknowledge bit. A group that has just been serviced stays blocked from the CPU until software clears its acknowledge bit, so an interrupt service routine can finish a group before the next request from it arrives.

When the CPU takes an interrupt, the block picks the winning group and the winning source inside it, clears that source's flag, sets the group's acknowledge bit, and returns a vector index one cycle later. A control register selects between per-source vectors and one fallback vector per group, and also holds the global mask. All registers are reached through a simple single-cycle register bus with a combinational read path.

Top module: `pie_top`

## Requirements
- R1: A one-cycle high on `src_pulse[s]` sets the flag of source s (group s/8, bit s%8) at that clock edge, whether or not the source is enabled.
- R2: A group's CPU flag sets one clock edge after the group has a source that is both flagged and enabled while its acknowledge bit is clear.
- R3: `cpu_req` is high exactly when some CPU flag bit has its CPU enable bit set and the global mask (control bit 1) is clear.
- R4: While a group's acknowledge bit is set, that group's CPU flag does not set. Writing 1 to an acknowledge bit clears it; writing 0 leaves it unchanged.
- R5: A take (`cpu_take` high while `cpu_req` is high) selects the lowest-numbered requesting group and, inside it, the lowest-numbered enabled and flagged source; one cycle later `vec_valid` is high for one cycle and `vec_index` equals group*8 + bit (0-based).
- R6: On such a take with vector fetch enabled (control bit 0), the chosen source's flag and its group's CPU flag are cleared and the group's acknowledge bit is set.
- R7: With vector fetch disabled, a take returns `vec_index` = 96 + group, leaves all source flags unchanged and does not set the acknowledge bit.
- R8: If the chosen group has no enabled flagged source left at take time, `vec_index` is 96 + group, the acknowledge bit stays clear and the group's CPU flag is cleared.
- R9: `cpu_take` while `cpu_req` is low has no effect: `vec_valid` stays low and no flag or acknowledge bit changes.
- R10: Register map (16-bit data): 0 control {bit1 global mask, bit0 fetch enable}, resets to 0x0002; 1 acknowledge (write 1 to clear); 2 CPU enable; 3 CPU flag (write 1 to clear); 4+g group g enable; 16+g group g flag (write 1 to clear). All but control reset to zero; unmapped addresses read 0.
- R11: When a source pulse and a software clear of the same flag bit happen in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 96 | One-cycle event pulses, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| cpu_req | output | 1 | Interrupt request towards the CPU |
| cpu_take | input | 1 | CPU accepts the current request |
| vec_valid | output | 1 | Vector index valid, one cycle after a take |
| vec_index | output | 7 | Returned vector index |

## Verification
The embedded properties assume that `cpu_take` is a single-cycle strobe and that every input is held stable across the sampling edge; the bench drives all inputs on the falling edge and pulses `cpu_take` for exactly one cycle. They also assume software never writes an acknowledge bit to 1 to set it, which the register semantics make impossible, and the bench only ever writes acknowledge and flag registers with clear masks. Simultaneous pulse-and-clear traffic is produced only in the one directed case that targets it.

// File: rtl/pie_pkg.sv
package pie_pkg;
    localparam int unsigned DATA_W     = 16;
    localparam int unsigned A_CTRL     = 0;
    localparam int unsigned A_ACK      = 1;
    localparam int unsigned A_CEN      = 2;
    localparam int unsigned A_CFLG     = 3;
    localparam int unsigned A_GEN_BASE = 4;
    localparam int unsigned CTRL_FETCH = 0;
    localparam int unsigned CTRL_MASK  = 1;
endpackage

// File: rtl/pie_group.sv
module pie_group #(
    parameter int unsigned GS = 8,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GS-1:0] src_pulse,
    input  logic          en_we,
    input  logic          flag_clr_we,
    input  logic [GS-1:0] wdata,
    input  logic          take_clr,
    input  logic          ack,
    output logic [GS-1:0] en_o,
    output logic [GS-1:0] flag_o,
    output logic          has_src,
    output logic          line,
    output logic [IW-1:0] src_idx
);
    typedef struct packed {
        logic [GS-1:0] en;
        logic [GS-1:0] flag;
    } grp_state_t;

    grp_state_t    st_d, st_q;
    logic [GS-1:0] pend;
    logic [GS-1:0] clr_mask;

    always_comb begin
        pend    = st_q.flag & st_q.en;
        has_src = |pend;
        src_idx = '0;
        for (int i = int'(GS) - 1; i >= 0; i--) begin
            if (pend[i]) src_idx = IW'(i);
        end
        line = has_src & ~ack;

        clr_mask = '0;
        if (flag_clr_we) clr_mask = wdata;
        if (take_clr)    clr_mask[src_idx] = 1'b1;

        st_d = st_q;
        if (en_we) st_d.en = wdata;
        st_d.flag = (st_q.flag & ~clr_mask) | src_pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign flag_o = st_q.flag;

    p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pulse != '0) |=> ((st_q.flag & $past(src_pulse)) == $past(src_pulse)));

    p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_clr && !src_pulse[src_idx]) |=> !st_q.flag[$past(src_idx)]);
endmodule

// File: rtl/pie_core.sv
module pie_core
    import pie_pkg::*;
#(
    parameter int unsigned NG = 12,
    parameter int unsigned GS = 8,
    parameter int unsigned IW = 3,
    parameter int unsigned VW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NG-1:0]        grp_line,
    input  logic [NG-1:0]        grp_has,
    input  logic [NG-1:0][IW-1:0] grp_idx,
    input  logic                 take,
    input  logic                 ctrl_we,
    input  logic                 ack_we,
    input  logic                 cen_we,
    input  logic                 cflg_we,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NG-1:0]        take_clr,
    output logic [NG-1:0]        ack_o,
    output logic [NG-1:0]        cen_o,
    output logic [NG-1:0]        cflag_o,
    output logic                 fetch_en_o,
    output logic                 gmask_o,
    output logic                 req,
    output logic                 vec_valid,
    output logic [VW-1:0]        vec_index
);
    localparam int unsigned NS = NG * GS;
    localparam int unsigned GW = (NG > 1) ? $clog2(NG) : 1;

    typedef struct packed {
        logic [NG-1:0] ack;
        logic [NG-1:0] cen;
        logic [NG-1:0] cflag;
        logic          fetch_en;
        logic          gmask;
        logic          vv;
        logic [VW-1:0] vidx;
    } core_state_t;

    core_state_t   st_d, st_q;
    logic [NG-1:0] pending;
    logic [GW-1:0] sel;
    logic          take_ok;
    logic          sel_has;
    logic [IW-1:0] sel_idx;
    logic          serve_src;
    logic [NG-1:0] sel_oh;
    logic [NG-1:0] ack_set;
    logic [NG-1:0] ack_clr;
    logic [NG-1:0] cflg_clr;

    always_comb begin
        pending = st_q.cflag & st_q.cen;
        req     = (|pending) & ~st_q.gmask;
        sel     = '0;
        for (int g = int'(NG) - 1; g >= 0; g--) begin
            if (pending[g]) sel = GW'(g);
        end
        sel_has = grp_has[sel];
        sel_idx = grp_idx[sel];
        take_ok = take & req;
        serve_src = take_ok & st_q.fetch_en & sel_has;

        sel_oh      = '0;
        sel_oh[sel] = 1'b1;
        take_clr    = serve_src ? sel_oh : '0;
        ack_set     = take_clr;
        ack_clr     = ack_we ? wdata[NG-1:0] : '0;
        cflg_clr    = (cflg_we ? wdata[NG-1:0] : '0) | (take_ok ? sel_oh : '0);

        st_d = st_q;
        if (ctrl_we) begin
            st_d.fetch_en = wdata[CTRL_FETCH];
            st_d.gmask    = wdata[CTRL_MASK];
        end
        if (cen_we) st_d.cen = wdata[NG-1:0];
        st_d.ack   = (st_q.ack & ~ack_clr) | ack_set;
        st_d.cflag = (st_q.cflag & ~cflg_clr) | (grp_line & ~ack_set);
        st_d.vv    = take_ok;
        if (take_ok) begin
            if (st_q.fetch_en && sel_has)
                st_d.vidx = VW'(int'(sel) * int'(GS) + int'(sel_idx));
            else
                st_d.vidx = VW'(int'(NS) + int'(sel));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.gmask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o      = st_q.ack;
    assign cen_o      = st_q.cen;
    assign cflag_o    = st_q.cflag;
    assign fetch_en_o = st_q.fetch_en;
    assign gmask_o    = st_q.gmask;
    assign vec_valid  = st_q.vv;
    assign vec_index  = st_q.vidx;

    p_ack_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ack & grp_line) == '0);

    p_ack_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|take_clr) |=> ((st_q.ack & $past(take_clr)) == $past(take_clr)));

    p_vec_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(take));

    p_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req) |=> !vec_valid);

    p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (int'(vec_index) < int'(NS + NG)));
endmodule

// File: rtl/pie_top.sv
module pie_top
    import pie_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 12,
    parameter int unsigned GROUP_SIZE = 8,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned VEC_W      = $clog2(NUM_GROUPS * GROUP_SIZE + NUM_GROUPS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_GROUPS*GROUP_SIZE-1:0] src_pulse,
    input  logic                             bus_sel,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic                             cpu_req,
    input  logic                             cpu_take,
    output logic                             vec_valid,
    output logic [VEC_W-1:0]                 vec_index
);
    localparam int unsigned NG         = NUM_GROUPS;
    localparam int unsigned GS         = GROUP_SIZE;
    localparam int unsigned IW         = (GS > 1) ? $clog2(GS) : 1;
    localparam int unsigned GFL_BASE   = A_GEN_BASE + NG;

    logic                 wr_en;
    logic                 ctrl_we, ack_we, cen_we, cflg_we;
    logic [NG-1:0]        gen_we, gfl_we;
    logic [NG-1:0]        grp_line, grp_has, take_clr;
    logic [NG-1:0][IW-1:0] grp_idx;
    logic [NG-1:0][GS-1:0] gen_arr, gfl_arr;
    logic [NG-1:0]        ack_q, cen_q, cflag_q;
    logic                 fetch_en_q, gmask_q;

    assign wr_en   = bus_sel & bus_wr;
    assign ctrl_we = wr_en && (bus_addr == ADDR_W'(A_CTRL));
    assign ack_we  = wr_en && (bus_addr == ADDR_W'(A_ACK));
    assign cen_we  = wr_en && (bus_addr == ADDR_W'(A_CEN));
    assign cflg_we = wr_en && (bus_addr == ADDR_W'(A_CFLG));

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign gen_we[g] = wr_en && (bus_addr == ADDR_W'(A_GEN_BASE + g));
        assign gfl_we[g] = wr_en && (bus_addr == ADDR_W'(GFL_BASE + g));

        pie_group #(.GS(GS), .IW(IW)) u_group (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_pulse   (src_pulse[g*GS +: GS]),
            .en_we       (gen_we[g]),
            .flag_clr_we (gfl_we[g]),
            .wdata       (bus_wdata[GS-1:0]),
            .take_clr    (take_clr[g]),
            .ack         (ack_q[g]),
            .en_o        (gen_arr[g]),
            .flag_o      (gfl_arr[g]),
            .has_src     (grp_has[g]),
            .line        (grp_line[g]),
            .src_idx     (grp_idx[g])
        );
    end

    pie_core #(.NG(NG), .GS(GS), .IW(IW), .VW(VEC_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_line   (grp_line),
        .grp_has    (grp_has),
        .grp_idx    (grp_idx),
        .take       (cpu_take),
        .ctrl_we    (ctrl_we),
        .ack_we     (ack_we),
        .cen_we     (cen_we),
        .cflg_we    (cflg_we),
        .wdata      (bus_wdata),
        .take_clr   (take_clr),
        .ack_o      (ack_q),
        .cen_o      (cen_q),
        .cflag_o    (cflag_q),
        .fetch_en_o (fetch_en_q),
        .gmask_o    (gmask_q),
        .req        (cpu_req),
        .vec_valid  (vec_valid),
        .vec_index  (vec_index)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CTRL)) begin
            bus_rdata[CTRL_FETCH] = fetch_en_q;
            bus_rdata[CTRL_MASK]  = gmask_q;
        end
        if (bus_addr == ADDR_W'(A_ACK))  bus_rdata[NG-1:0] = ack_q;
        if (bus_addr == ADDR_W'(A_CEN))  bus_rdata[NG-1:0] = cen_q;
        if (bus_addr == ADDR_W'(A_CFLG)) bus_rdata[NG-1:0] = cflag_q;
        for (int g = 0; g < int'(NG); g++) begin
            if (bus_addr == ADDR_W'(int'(A_GEN_BASE) + g)) bus_rdata[GS-1:0] = gen_arr[g];
            if (bus_addr == ADDR_W'(int'(GFL_BASE) + g))   bus_rdata[GS-1:0] = gfl_arr[g];
        end
    end
endmodule

// File: tb/pie_top_bench.sv
module pie_top_bench;
    localparam int NS = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_pulse = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          cpu_req;
    logic          cpu_take = 1'b0;
    logic          vec_valid;
    logic [6:0]    vec_index;

    int checks = 0;
    int failures = 0;

    pie_top u_pie_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_req   (cpu_req),
        .cpu_take  (cpu_take),
        .vec_valid (vec_valid),
        .vec_index (vec_index)
    );

    always #4 clk = ~clk;

    // Each row: first source, second source, expected vector
    localparam int VT [0:7][0:2] = '{
        '{5, 5, 5}, '{0, 95, 0}, '{9, 8, 8}, '{17, 40, 17},
        '{47, 41, 41}, '{88, 95, 88}, '{23, 16, 16}, '{60, 63, 60}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input int data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = 5'(addr); bus_wdata = 16'(data);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int addr, output int data);
        bus_addr = 5'(addr);
        #1;
        data = int'(bus_rdata);
    endtask

    task automatic pulse2(input int a, input int b);
        @(negedge clk);
        src_pulse = '0;
        src_pulse[a] = 1'b1;
        src_pulse[b] = 1'b1;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic take_once();
        @(negedge clk);
        cpu_take = 1'b1;
        @(negedge clk);
        cpu_take = 1'b0;
    endtask

    task automatic clear_all();
        for (int g = 0; g < 12; g++) bus_write(16 + g, 16'hFF);
        bus_write(1, 16'hFFF);
        bus_write(3, 16'hFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset values
        bus_read(0, rd); check("R10 ctrl reset", rd, 2);
        bus_read(1, rd); check("R10 ack reset", rd, 0);
        bus_read(2, rd); check("R10 cen reset", rd, 0);
        bus_read(31, rd); check("R10 unmapped", rd, 0);
        check("R10 req reset", int'(cpu_req), 0);
        check("R10 vv reset", int'(vec_valid), 0);

        // R1 flag sets though disabled
        pulse2(26, 26);
        bus_read(19, rd); check("R1 flag without enable", rd, 8'h04);
        @(negedge clk);
        bus_read(3, rd); check("R2 no cpu flag when disabled", rd, 0);
        bus_write(19, 16'hFF);

        // R9 take with no request
        take_once();
        check("R9 no vec_valid", int'(vec_valid), 0);
        bus_read(1, rd); check("R9 ack untouched", rd, 0);

        // setup
        bus_write(2, 16'hFFF);
        for (int g = 0; g < 12; g++) bus_write(4 + g, 16'hFF);
        bus_read(6, rd); check("R10 group enable readback", rd, 8'hFF);
        bus_write(0, 16'h0001);

        // vector table: R5 priority and R6 clearing
        for (int k = 0; k < 8; k++) begin
            pulse2(VT[k][0], VT[k][1]);
            @(negedge clk);
            check("R3 req after pulse", int'(cpu_req), 1);
            take_once();
            check("R5 vec_valid", int'(vec_valid), 1);
            check("R5 vec_index", int'(vec_index), VT[k][2]);
            bus_read(1, rd);
            check("R6 ack set", (rd >> (VT[k][2] / 8)) & 1, 1);
            bus_read(16 + VT[k][2] / 8, rd);
            check("R6 source flag cleared", (rd >> (VT[k][2] % 8)) & 1, 0);
            clear_all();
        end

        // R2 latency and R4 ack gating
        pulse2(12, 12);
        bus_read(3, rd); check("R2 cpu flag not yet", rd, 0);
        @(negedge clk);
        bus_read(3, rd); check("R2 cpu flag set", rd, 2);
        take_once();
        check("R5 vec 12", int'(vec_index), 12);
        pulse2(13, 13);
        @(negedge clk); @(negedge clk);
        bus_read(3, rd); check("R4 cpu flag blocked", rd, 0);
        check("R4 req blocked", int'(cpu_req), 0);
        bus_write(1, 16'h0000);
        bus_read(1, rd); check("R4 write 0 no effect", rd, 2);
        bus_write(1, 16'h0002);
        bus_read(1, rd); check("R4 write 1 clears", rd, 0);
        @(negedge clk);
        check("R4 req after ack clear", int'(cpu_req), 1);
        take_once();
        check("R5 vec 13", int'(vec_index), 13);
        clear_all();

        // R3 global mask and CPU enable
        bus_write(0, 16'h0003);
        pulse2(70, 70);
        @(negedge clk); @(negedge clk);
        check("R3 masked", int'(cpu_req), 0);
        bus_write(0, 16'h0001);
        check("R3 unmasked", int'(cpu_req), 1);
        bus_write(2, 16'hFFF & ~(1 << 8));
        check("R3 cpu enable off", int'(cpu_req), 0);
        bus_read(3, rd); check("R3 cpu flag still set", rd, 1 << 8);
        bus_write(2, 16'hFFF);
        clear_all();

        // R7 fetch disabled
        bus_write(0, 16'h0000);
        pulse2(30, 30);
        @(negedge clk);
        take_once();
        check("R7 vec_index", int'(vec_index), 99);
        bus_read(19, rd); check("R7 source flag kept", rd, 8'h40);
        bus_read(1, rd); check("R7 ack not set", rd, 0);
        clear_all();
        bus_write(0, 16'h0001);

        // R8 flag vanished before take
        pulse2(50, 50);
        @(negedge clk);
        bus_write(22, 16'h04);
        take_once();
        check("R8 vec_index", int'(vec_index), 102);
        bus_read(1, rd); check("R8 ack clear", rd, 0);
        @(negedge clk);
        bus_read(3, rd); check("R8 cpu flag cleared", rd, 0);
        clear_all();

        // R11 set beats clear
        @(negedge clk);
        src_pulse[35] = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'(20); bus_wdata = 16'h08;
        @(negedge clk);
        src_pulse = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(20, rd); check("R11 set wins", rd, 8'h08);
        clear_all();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule